// File: doc/BRIEF.md
# Glitch-free audio master clock switch

This block picks one of two free-running audio master clocks that have no phase or frequency relation to each other, and drives a single clock output. The faster source belongs to the 48 kHz sample-rate family (36.864 MHz). The slower one belongs to the 44.1 kHz family (33.8688 MHz). A level select input chooses the source, and it may change at any moment with no relation to either clock. Each handover follows a fixed pattern. The old clock keeps running until two of its own falling edges have passed, and the output then parks low. The new clock appears only after two of its own falling edges have passed, counted from the moment the old path went quiet. No output pulse is ever cut short.

A run input holds the output low while it is low; this is the power-down state. Stopping and restarting through the run input follow the same two-edge pattern. Board-level pull-ups, which keep both select and run high when the pins are left open, lie outside this RTL. The reset is synchronous and active high, and each clock domain samples it on its own falling edges. Reset clears both paths. When reset is released, the requested source starts through the normal two-edge sequence.

Top module: `clk_glitchfree_mux`

## Requirements
- R1: With sel_hi high, run high and the switch settled, clk_out follows clk_hi_fam exactly.
- R2: With sel_hi low, run high and the switch settled, clk_out follows clk_lo_fam exactly.
- R3: After the request moves away from the running source, clk_out keeps following that source up to its second falling edge after the change, and is low from that edge on.
- R4: Once the old path has stopped, clk_out stays low until the second falling edge of the newly requested clock after the stop. From that edge on, clk_out follows the new clock.
- R5: The two clock paths are never enabled together.
- R6: Every high pulse on clk_out lasts exactly half a period of one of the two sources. No low interval is shorter than half a period of the faster source.
- R7: While run is low, clk_out is parked low after the two-edge stop. Raising run starts the selected source through the R4 sequence. While run is low, a change of sel_hi starts nothing.
- R8: While rst is high, both paths are cleared and clk_out is low. After rst falls, the requested source starts through the R4 sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_hi_fam | input | 1 | 48 kHz-family master clock (36.864 MHz), chosen when sel_hi is high |
| clk_lo_fam | input | 1 | 44.1 kHz-family master clock (33.8688 MHz), chosen when sel_hi is low |
| rst | input | 1 | Synchronous active-high reset, sampled on falling edges in each domain |
| sel_hi | input | 1 | Asynchronous source select: 1 = clk_hi_fam, 0 = clk_lo_fam |
| run | input | 1 | Asynchronous output enable: 0 parks clk_out low (power-down) |
| clk_out | output | 1 | Switched clock output |

## Verification
The assertions assume three things about the inputs. First, sel_hi and run stay stable long enough for a handover to finish before they move again. Second, rst is held for several periods of both clocks. Third, no input edge lands on the same instant as a clock edge. The stimulus meets these conditions in a fixed way. The two clock periods have a greatest common divisor that does not divide the offset between their edge trains, so their edges never coincide. All input changes fall on a time grid that is offset from every clock edge. Each select or run change is followed by a random wait of at least 440 ns, which is many times longer than the slowest handover. Because the changes land at many different phases of both clocks, every handover is exercised from a fresh starting phase.

// File: rtl/gfm_pkg.sv
`timescale 1ps/1ps
package gfm_pkg;

    // Source index: bit position of each leg in the enable vectors
    typedef enum logic {
        SRC_LO = 1'b0,   // 44.1 kHz family
        SRC_HI = 1'b1    // 48 kHz family
    } src_e;

    localparam int NUM_SRC    = 2;
    localparam int MIN_STAGES = 2;

    // True when the requested source matches this leg and the output may run
    function automatic logic wants(src_e leg, logic sel_hi, logic run);
        return run && (sel_hi == logic'(leg));
    endfunction

endpackage

// File: rtl/gfm_negsync.sv
`timescale 1ps/1ps
module gfm_negsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int DEPTH = (STAGES < gfm_pkg::MIN_STAGES) ? gfm_pkg::MIN_STAGES : STAGES;

    logic [DEPTH-1:0] chain;

    // Falling-edge shift chain: the enable can only change while the clock is low
    always_ff @(negedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[DEPTH-2:0], d};
        end
    end

    assign q = chain[DEPTH-1];

endmodule

// File: rtl/gfm_leg.sv
`timescale 1ps/1ps
module gfm_leg
    import gfm_pkg::*;
#(
    parameter src_e SRC    = SRC_LO,
    parameter int   STAGES = 2
) (
    input  logic clk_src,
    input  logic rst,
    input  logic sel_hi,
    input  logic run,
    input  logic peer_en,
    output logic en,
    output logic gclk
);
    logic req;

    // A leg asks to run only while the other leg reports itself stopped
    assign req = wants(SRC, sel_hi, run) && !peer_en;

    gfm_negsync #(.STAGES(STAGES)) u_sync (
        .clk (clk_src),
        .rst (rst),
        .d   (req),
        .q   (en)
    );

    // en moves only while clk_src is low, so the AND never clips a pulse
    assign gclk = clk_src & en;

endmodule

// File: rtl/clk_glitchfree_mux.sv
`timescale 1ps/1ps
module clk_glitchfree_mux
    import gfm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_hi_fam,
    input  logic clk_lo_fam,
    input  logic rst,
    input  logic sel_hi,
    input  logic run,
    output logic clk_out
);
    logic [NUM_SRC-1:0] src_clk;
    logic [NUM_SRC-1:0] src_en;
    logic [NUM_SRC-1:0] src_gclk;

    assign src_clk = {clk_hi_fam, clk_lo_fam};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_leg
        localparam src_e LEG_SRC = (i == 1) ? SRC_HI : SRC_LO;

        gfm_leg #(
            .SRC    (LEG_SRC),
            .STAGES (SYNC_STAGES)
        ) u_leg (
            .clk_src (src_clk[i]),
            .rst     (rst),
            .sel_hi  (sel_hi),
            .run     (run),
            .peer_en (src_en[NUM_SRC-1-i]),
            .en      (src_en[i]),
            .gclk    (src_gclk[i])
        );
    end

    // At most one gated clock is live, so the OR adds no edges of its own
    assign clk_out = |src_gclk;

endmodule

// File: rtl/gfm_chk.sv
`timescale 1ps/1ps
module gfm_chk (
    input logic       clk_hi_fam,
    input logic       clk_lo_fam,
    input logic       rst,
    input logic       sel_hi,
    input logic       run,
    input logic [1:0] src_en,
    input logic       clk_out
);
    // R5: exclusivity seen from each domain
    assert_one_path_hi_R5: assert property (@(negedge clk_hi_fam) disable iff (rst)
        $onehot0(src_en));
    assert_one_path_lo_R5: assert property (@(negedge clk_lo_fam) disable iff (rst)
        $onehot0(src_en));

    // R3: a path only stops when it is no longer requested
    assert_stop_unwanted_hi_R3: assert property (@(negedge clk_hi_fam) disable iff (rst)
        $fell(src_en[1]) |-> !(run && sel_hi));
    assert_stop_unwanted_lo_R3: assert property (@(negedge clk_lo_fam) disable iff (rst)
        $fell(src_en[0]) |-> !(run && !sel_hi));

    // R4: a path only starts with its peer already stopped
    assert_start_peer_off_hi_R4: assert property (@(negedge clk_hi_fam) disable iff (rst)
        $rose(src_en[1]) |-> !src_en[0]);
    assert_start_peer_off_lo_R4: assert property (@(negedge clk_lo_fam) disable iff (rst)
        $rose(src_en[0]) |-> !src_en[1]);

    // R7: with no path enabled the output sits low
    assert_parked_low_R7: assert property (@(posedge clk_hi_fam) disable iff (rst)
        (src_en == 2'b00) |-> !clk_out);

    // R8: reset held across an edge leaves the leg cleared
    assert_reset_clear_hi_R8: assert property (@(negedge clk_hi_fam)
        (rst && $past(rst)) |-> !src_en[1]);
    assert_reset_clear_lo_R8: assert property (@(negedge clk_lo_fam)
        (rst && $past(rst)) |-> !src_en[0]);

endmodule

bind clk_glitchfree_mux gfm_chk u_gfm_chk (
    .clk_hi_fam (clk_hi_fam),
    .clk_lo_fam (clk_lo_fam),
    .rst        (rst),
    .sel_hi     (sel_hi),
    .run        (run),
    .src_en     (src_en),
    .clk_out    (clk_out)
);

// File: tb/clk_glitchfree_mux_bench.sv
`timescale 1ps/1ps
module clk_glitchfree_mux_bench;

    localparam int HALF_HI_PS    = 13563;   // 36.864 MHz
    localparam int HALF_LO_PS    = 14762;   // 33.8688 MHz
    localparam int LO_OFFSET_PS  = 3001;
    localparam int STEP_PS       = 22;      // stimulus grid, never on a clock edge
    localparam int SAMPLE_PS     = 2002;
    localparam int FIRST_SAMPLE  = 66016;
    localparam int WATCHDOG_CYC  = 200000;

    logic clk_hi_fam = 1'b0;
    logic clk_lo_fam = 1'b0;
    logic rst        = 1'b1;
    logic sel_hi     = 1'b1;
    logic run        = 1'b1;
    logic clk_out;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit armed  = 1'b0;
    bit done   = 1'b0;

    // Reference model: -1 = parked, 0 = low family, 1 = high family
    int cur = -1;
    int stop_cnt [2] = '{0, 0};
    int start_cnt[2] = '{0, 0};

    time t_rise = 0;
    time t_fall = 0;
    bit  seen_rise = 1'b0;
    bit  seen_fall = 1'b0;

    clk_glitchfree_mux u_clk_glitchfree_mux (
        .clk_hi_fam (clk_hi_fam),
        .clk_lo_fam (clk_lo_fam),
        .rst        (rst),
        .sel_hi     (sel_hi),
        .run        (run),
        .clk_out    (clk_out)
    );

    initial forever #HALF_HI_PS clk_hi_fam = ~clk_hi_fam;
    initial begin
        #LO_OFFSET_PS;
        forever #HALF_LO_PS clk_lo_fam = ~clk_lo_fam;
    end

    function automatic int want_src();
        if (!run) return -1;
        return sel_hi ? 1 : 0;
    endfunction

    task automatic model_edge(input int src);
        if (rst) begin
            if (cur == src) cur = -1;
            stop_cnt[src]  = 0;
            start_cnt[src] = 0;
            return;
        end
        if (cur == src && want_src() != src) begin
            stop_cnt[src]++;
            if (stop_cnt[src] == 2) begin
                cur = -1;
                stop_cnt[src] = 0;
            end
        end else begin
            stop_cnt[src] = 0;
        end
        if (cur == -1 && want_src() == src) begin
            start_cnt[src]++;
            if (start_cnt[src] == 2) begin
                cur = src;
                start_cnt[src] = 0;
            end
        end else begin
            start_cnt[src] = 0;
        end
    endtask

    always @(negedge clk_hi_fam) model_edge(1);
    always @(negedge clk_lo_fam) model_edge(0);

    // Sampled comparison against the model
    initial begin
        #FIRST_SAMPLE;
        armed = 1'b1;
        forever begin
            logic exp_v;
            string tag;
            exp_v = (cur == 1) ? clk_hi_fam : (cur == 0) ? clk_lo_fam : 1'b0;
            if (rst)                                tag = "R8";
            else if (cur == -1 && want_src() == -1) tag = "R7";
            else if (cur == -1)                     tag = "R4";
            else if (cur != want_src())             tag = "R3";
            else if (cur == 1)                      tag = "R1";
            else                                    tag = "R2";
            n_cmp++;
            if (clk_out !== exp_v) begin
                n_bad++;
                $display("FAIL %s: clk_out=%0b expected=%0b at %0t", tag, clk_out, exp_v, $time);
            end
            #SAMPLE_PS;
        end
    end

    // R5 R6: pulse widths at the port
    always @(clk_out) begin
        if (armed && clk_out === 1'b0) begin
            if (seen_rise) begin
                time w;
                w = $time - t_rise;
                n_cmp++;
                if (w != HALF_HI_PS && w != HALF_LO_PS) begin
                    n_bad++;
                    $display("FAIL R5 R6: high width=%0t expected=%0d or %0d", w, HALF_HI_PS, HALF_LO_PS);
                end
            end
            t_fall = $time;
            seen_fall = 1'b1;
        end else if (armed && clk_out === 1'b1) begin
            if (seen_fall) begin
                time w;
                w = $time - t_fall;
                n_cmp++;
                if (w < HALF_HI_PS) begin
                    n_bad++;
                    $display("FAIL R6: low width=%0t expected>=%0d", w, HALF_HI_PS);
                end
            end
            t_rise = $time;
            seen_rise = 1'b1;
        end
    end

    task automatic steps(input int n);
        #(STEP_PS * n);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk_hi_fam);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        #5;
        // R8: reset, then the high source comes up
        steps(5000);
        rst = 1'b0;
        steps(40000);
        // R2 R3 R4: hand over to the low family
        sel_hi = 1'b0;
        steps(40000);
        // R7: park, change select while parked, then resume
        run = 1'b0;
        steps(30000);
        sel_hi = 1'b1;
        steps(30000);
        run = 1'b1;
        steps(40000);
        // R8: reset in the middle of operation
        rst = 1'b1;
        steps(6000);
        rst = 1'b0;
        steps(30000);
        // Random phases
        for (int k = 0; k < 50; k++) begin
            if ($urandom_range(9, 0) < 2) run = ~run;
            else                          sel_hi = ~sel_hi;
            steps($urandom_range(60000, 20000));
        end
        run = 1'b1;
        steps(30000);
        done = 1'b1;
        finish_run();
    end

endmodule